// File: doc/BRIEF.md
# Halfword Pack and Bitfield Unit

This block is a single-stage datapath that performs five 32-bit operations. Two are halfword pack operations that join one half of each source operand. One is a bitfield insert, which becomes a bitfield clear when the source index is 15. The last two extract a bitfield, one with zero fill and one with sign extension. The operands come in with an operation select, two source values, the old destination value, a position field and a top field. The result, a valid strobe and an undefined-operation flag come out one clock later.

The block handles the instruction-level corner rules itself. A zero arithmetic shift amount means 31. An insert from index 15 writes zeros. A field whose msb lies below its lsb, or an extract that runs past bit 31, returns the old destination value and raises the undefined flag. The caller decodes the instruction and supplies the fields. The block does not fetch instructions or access a register file.

Top module: `hpbf_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted operation, out_valid, out_undef and out_result are all 0. Reset is asynchronous active-low and is released inside the block after two clock edges.
- R2: The result of an operation accepted with in_valid=1 appears on the next clock edge, with out_valid=1. A cycle with in_valid=0 gives out_valid=0 on the next edge, and out_result and out_undef keep their values.
- R3: op_sel=0 (pack bottom-top) gives result[15:0]=src_a[15:0] and result[31:16]=(src_b << pos_field)[31:16], with out_undef=0.
- R4: op_sel=1 (pack top-bottom) gives result[31:16]=src_a[31:16] and result[15:0]=(src_b >>> s)[15:0], where the shift is arithmetic and s=pos_field, except that s=31 when pos_field=0. out_undef=0.
- R5: op_sel=2 (insert), with lsb=pos_field and msb=top_field, msb>=lsb and src_is_r15=0, replaces bits msb..lsb of dest_old with the low msb-lsb+1 bits of src_a. All other bits are unchanged and out_undef=0.
- R6: An insert with src_is_r15=1 writes zeros into bits msb..lsb of dest_old. All other bits are unchanged.
- R7: An insert with lsb=0 and msb=31 returns the inserted source unchanged: src_a, or 0 when src_is_r15=1.
- R8: An insert with msb<lsb returns dest_old with out_undef=1.
- R9: op_sel=3 (unsigned extract), with width=top_field+1 and pos_field+width<=32, returns bits pos_field+width-1..pos_field of src_a, zero-filled above the field, with out_undef=0.
- R10: op_sel=4 (signed extract) returns the same field sign-extended from its top bit. A width of 32 returns src_a unchanged.
- R11: An extract with pos_field+top_field+1>32 returns dest_old with out_undef=1.
- R12: op_sel values 5, 6 and 7 are reserved. They return dest_old with out_undef=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation select (0..4, 5..7 reserved) |
| src_a | input | 32 | First source (pack low/high keep, insert/extract source) |
| src_b | input | 32 | Second source for pack operations |
| dest_old | input | 32 | Current destination value |
| pos_field | input | 5 | Shift amount or field lsb |
| top_field | input | 5 | Field msb (insert) or width minus one (extract) |
| src_is_r15 | input | 1 | Source index is 15: insert becomes clear |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Registered result |
| out_undef | output | 1 | Operation was undefined |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing and the holding of the output registers, the half that each pack operation keeps, the undefined cases with their pass-through of the old destination, the full-width insert, and the zero top bit of a narrow unsigned extract. Only the bench scenarios, compared against a bit-by-bit reference model, show the shifted halves, the shift-of-zero-means-31 rule, the merge positions of insert and clear, and the sign extension of extracts. The scenarios include the exact 32-bit boundary of an extract.

// File: rtl/hpbf_pkg.sv
package hpbf_pkg;
  localparam int HPBF_DATA_W = 32;
  localparam int HPBF_OP_W   = 3;

  typedef enum logic [HPBF_OP_W-1:0] {
    OP_PACK_BT   = 3'd0,
    OP_PACK_TB   = 3'd1,
    OP_INSERT    = 3'd2,
    OP_EXTRACT_U = 3'd3,
    OP_EXTRACT_S = 3'd4
  } hpbf_op_e;
endpackage

// File: rtl/hpbf_span_mask.sv
// Produces a mask with ones at bit positions lo..hi inclusive (empty if hi<lo).
module hpbf_span_mask #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  lo,
  input  logic [IDX_W-1:0]  hi,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [IDX_W-1:0] BIT_IDX = IDX_W'(i);
    assign mask[i] = (BIT_IDX >= lo) && (BIT_IDX <= hi);
  end
endmodule

// File: rtl/hpbf_pack.sv
// Halfword pack: one half from each operand, second operand shifted.
module hpbf_pack #(
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] keep_src,
  input  logic [DATA_W-1:0] shift_src,
  input  logic [IDX_W-1:0]  shamt,
  input  logic              top_bottom,
  output logic [DATA_W-1:0] value
);
  localparam logic [DATA_W-1:0] LO_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] HI_MASK = ~LO_MASK;

  logic [IDX_W-1:0]  asr_amt;
  logic [DATA_W-1:0] left_shifted;
  logic [DATA_W-1:0] right_shifted;

  always_comb begin
    asr_amt       = (shamt == '0) ? {IDX_W{1'b1}} : shamt;
    left_shifted  = shift_src << shamt;
    right_shifted = DATA_W'($signed(shift_src) >>> asr_amt);
    if (top_bottom) begin
      value = (keep_src & HI_MASK) | (right_shifted & LO_MASK);
    end else begin
      value = (keep_src & LO_MASK) | (left_shifted & HI_MASK);
    end
  end
endmodule

// File: rtl/hpbf_insert.sv
// Bitfield insert / clear into the old destination value.
module hpbf_insert #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dest_old,
  input  logic [IDX_W-1:0]  lsb,
  input  logic [IDX_W-1:0]  msb,
  input  logic              zero_src,
  output logic [DATA_W-1:0] value,
  output logic              undef
);
  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] ins_src;
  logic [DATA_W-1:0] placed;
  logic              full_width;

  hpbf_span_mask #(.DATA_W(DATA_W)) u_mask (
    .lo   (lsb),
    .hi   (msb),
    .mask (field_mask)
  );

  always_comb begin
    ins_src    = zero_src ? '0 : src;
    placed     = ins_src << lsb;
    undef      = (msb < lsb);
    full_width = (lsb == '0) && (msb == {IDX_W{1'b1}});
    if (undef) begin
      value = dest_old;
    end else if (full_width) begin
      value = ins_src;
    end else begin
      value = (dest_old & ~field_mask) | (placed & field_mask);
    end
  end
endmodule

// File: rtl/hpbf_extract.sv
// Signed / unsigned bitfield extract with overrun detection.
module hpbf_extract #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dest_old,
  input  logic [IDX_W-1:0]  lsb,
  input  logic [IDX_W-1:0]  width_m1,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] value,
  output logic              undef
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DATA_W);

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] aligned;
  logic [IDX_W:0]    end_pos;
  logic              top_bit;

  hpbf_span_mask #(.DATA_W(DATA_W)) u_mask (
    .lo   ('0),
    .hi   (width_m1),
    .mask (keep_mask)
  );

  always_comb begin
    end_pos = {1'b0, lsb} + {1'b0, width_m1};
    undef   = (end_pos >= LIMIT);
    aligned = src >> lsb;
    top_bit = aligned[width_m1];
    if (undef) begin
      value = dest_old;
    end else if (sign_ext && top_bit) begin
      value = (aligned & keep_mask) | ~keep_mask;
    end else begin
      value = aligned & keep_mask;
    end
  end
endmodule

// File: rtl/hpbf_unit.sv
module hpbf_unit
  import hpbf_pkg::*;
#(
  parameter int DATA_W    = HPBF_DATA_W,
  parameter int RST_STAGES = 2,
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dest_old,
  input  logic [IDX_W-1:0]  pos_field,
  input  logic [IDX_W-1:0]  top_field,
  input  logic              src_is_r15,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_undef
);
  // Reset: asserted asynchronously, released through a flop chain.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  // Operation datapaths.
  logic [DATA_W-1:0] pack_val;
  logic [DATA_W-1:0] ins_val;
  logic [DATA_W-1:0] ext_val;
  logic              ins_undef;
  logic              ext_undef;

  hpbf_pack #(.DATA_W(DATA_W)) u_pack (
    .keep_src   (src_a),
    .shift_src  (src_b),
    .shamt      (pos_field),
    .top_bottom (op_sel == OP_PACK_TB),
    .value      (pack_val)
  );

  hpbf_insert #(.DATA_W(DATA_W)) u_insert (
    .src      (src_a),
    .dest_old (dest_old),
    .lsb      (pos_field),
    .msb      (top_field),
    .zero_src (src_is_r15),
    .value    (ins_val),
    .undef    (ins_undef)
  );

  hpbf_extract #(.DATA_W(DATA_W)) u_extract (
    .src      (src_a),
    .dest_old (dest_old),
    .lsb      (pos_field),
    .width_m1 (top_field),
    .sign_ext (op_sel == OP_EXTRACT_S),
    .value    (ext_val),
    .undef    (ext_undef)
  );

  // Next-state selection.
  logic [DATA_W-1:0] sel_val;
  logic              sel_undef;
  logic              valid_d;
  logic [DATA_W-1:0] result_d;
  logic              undef_d;
  logic              data_en;

  always_comb begin
    case (op_sel)
      OP_PACK_BT, OP_PACK_TB: begin
        sel_val   = pack_val;
        sel_undef = 1'b0;
      end
      OP_INSERT: begin
        sel_val   = ins_val;
        sel_undef = ins_undef;
      end
      OP_EXTRACT_U, OP_EXTRACT_S: begin
        sel_val   = ext_val;
        sel_undef = ext_undef;
      end
      default: begin
        sel_val   = dest_old;
        sel_undef = 1'b1;
      end
    endcase
  end

  always_comb begin
    data_en  = in_valid;
    valid_d  = in_valid;
    result_d = out_result;
    undef_d  = out_undef;
    if (data_en) begin
      result_d = sel_val;
      undef_d  = sel_undef;
    end
  end

  // Output registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_undef  <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      out_result <= result_d;
      out_undef  <= undef_d;
    end
  end
endmodule

// File: rtl/hpbf_unit_chk.sv
module hpbf_unit_chk
  import hpbf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op_sel,
  input logic [31:0] src_a,
  input logic [31:0] dest_old,
  input logic [4:0]  pos_field,
  input logic [4:0]  top_field,
  input logic        src_is_r15,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_undef
);
  logic [5:0] ext_end;
  assign ext_end = {1'b0, pos_field} + {1'b0, top_field};

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_undef)));

  assert_pack_bt_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_PACK_BT) |=> (!out_undef && out_result[15:0] == $past(src_a[15:0])));

  assert_pack_tb_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_PACK_TB) |=> (!out_undef && out_result[31:16] == $past(src_a[31:16])));

  assert_full_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_INSERT && pos_field == 5'd0 && top_field == 5'd31 && !src_is_r15)
      |=> (!out_undef && out_result == $past(src_a)));

  assert_insert_inverted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_INSERT && top_field < pos_field)
      |=> (out_undef && out_result == $past(dest_old)));

  assert_extract_u_top_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_EXTRACT_U && top_field != 5'd31 && ext_end < 6'd32)
      |=> (!out_undef && !out_result[31]));

  assert_extract_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == OP_EXTRACT_U || op_sel == OP_EXTRACT_S) && ext_end >= 6'd32)
      |=> (out_undef && out_result == $past(dest_old)));

  assert_reserved_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > 3'd4) |=> (out_undef && out_result == $past(dest_old)));
endmodule

bind hpbf_unit hpbf_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .src_a      (src_a),
  .dest_old   (dest_old),
  .pos_field  (pos_field),
  .top_field  (top_field),
  .src_is_r15 (src_is_r15),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_undef  (out_undef)
);

// File: tb/hpbf_unit_tb_top.sv
module hpbf_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] dest_old;
  logic [4:0]  pos_field;
  logic [4:0]  top_field;
  logic        src_is_r15;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_undef;

  int n_tests;
  int n_fail;

  hpbf_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .dest_old(dest_old),
    .pos_field(pos_field), .top_field(top_field), .src_is_r15(src_is_r15),
    .out_valid(out_valid), .out_result(out_result), .out_undef(out_undef)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: {undef, value}
  function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] d, input int pos, input int top,
      input logic r15);
    logic [31:0] t;
    logic [31:0] r;
    logic [31:0] s;
    int sh;
    case (op)
      3'd0: begin
        t = b << pos;
        return {1'b0, t[31:16], a[15:0]};
      end
      3'd1: begin
        sh = (pos == 0) ? 31 : pos;
        t = $signed(b) >>> sh;
        return {1'b0, a[31:16], t[15:0]};
      end
      3'd2: begin
        if (top < pos) return {1'b1, d};
        s = r15 ? 32'd0 : a;
        for (int i = 0; i < 32; i++)
          r[i] = (i >= pos && i <= top) ? s[i-pos] : d[i];
        return {1'b0, r};
      end
      3'd3, 3'd4: begin
        if (pos + top + 1 > 32) return {1'b1, d};
        for (int i = 0; i < 32; i++)
          r[i] = (i <= top) ? a[pos+i] : ((op == 3'd4) ? a[pos+top] : 1'b0);
        return {1'b0, r};
      end
      default: return {1'b1, d};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input int pos, input int top,
      input logic r15);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: begin
        if (top < pos) return "R8";
        if (pos == 0 && top == 31) return "R7";
        if (r15) return "R6";
        return "R5";
      end
      3'd3: return (pos + top + 1 > 32) ? "R11" : "R9";
      3'd4: return (pos + top + 1 > 32) ? "R11" : "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual valid/undef/result=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives, waits one negedge, checks.
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] d, input int pos, input int top, input logic r15);
    logic [32:0] exp;
    in_valid   = 1'b1;
    op_sel     = op;
    src_a      = a;
    src_b      = b;
    dest_old   = d;
    pos_field  = 5'(pos);
    top_field  = 5'(top);
    src_is_r15 = r15;
    exp = model(op, a, b, d, pos, top, r15);
    @(negedge clk);
    check(tag_of(op, pos, top, r15), {out_valid, out_undef, out_result}, {1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [33:0] held;
    n_tests = 0;
    n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; src_a = '0; src_b = '0;
    dest_old = '0; pos_field = '0; top_field = '0; src_is_r15 = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_undef, out_result}, 34'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {out_valid, out_undef, out_result}, 34'd0);

    // Directed corners
    run_op(3'd0, 32'h1234ABCD, 32'h00005678, 32'h0, 8, 0, 1'b0);   // R3
    run_op(3'd1, 32'hDEAD0000, 32'h80000000, 32'h0, 0, 0, 1'b0);   // R4 zero shift = 31
    run_op(3'd1, 32'hDEAD0000, 32'h00012340, 32'h0, 4, 0, 1'b0);   // R4
    run_op(3'd2, 32'h00000005, 32'h0, 32'hFFFFFFFF, 4, 7, 1'b0);   // R5
    run_op(3'd2, 32'h12345678, 32'h0, 32'hFFFFFFFF, 8, 15, 1'b1);  // R6
    run_op(3'd2, 32'h13579BDF, 32'h0, 32'h0, 0, 31, 1'b0);         // R7
    run_op(3'd2, 32'h13579BDF, 32'h0, 32'hA5A5A5A5, 0, 31, 1'b1);  // R7 clear full
    run_op(3'd2, 32'h13579BDF, 32'h0, 32'hCAFEF00D, 10, 3, 1'b0);  // R8
    run_op(3'd3, 32'hF0F0ABCD, 32'h0, 32'h0, 12, 7, 1'b0);         // R9
    run_op(3'd3, 32'hF0F0ABCD, 32'h0, 32'h0, 20, 11, 1'b0);        // R9 exact boundary
    run_op(3'd4, 32'h00008000, 32'h0, 32'h0, 12, 3, 1'b0);         // R10
    run_op(3'd4, 32'h87654321, 32'h0, 32'h0, 0, 31, 1'b0);         // R10 width 32
    run_op(3'd3, 32'hFFFFFFFF, 32'h0, 32'h11112222, 20, 12, 1'b0); // R11
    run_op(3'd4, 32'hFFFFFFFF, 32'h0, 32'h33334444, 31, 1, 1'b0);  // R11
    run_op(3'd5, 32'h1, 32'h2, 32'h55556666, 1, 2, 1'b0);          // R12
    run_op(3'd7, 32'h1, 32'h2, 32'h77778888, 1, 2, 1'b0);          // R12

    // Idle cycle: outputs hold, valid drops (R2)
    held = {1'b0, out_undef, out_result};
    in_valid = 1'b0;
    src_a = 32'hFFFFFFFF; dest_old = 32'h0; op_sel = 3'd0;
    @(negedge clk);
    check("R2", {out_valid, out_undef, out_result}, held);

    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = ($urandom_range(0, 15) < 14) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
      run_op(op, $urandom, $urandom, $urandom, $urandom_range(0, 31),
             $urandom_range(0, 31), ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 9) == 0) begin
        held = {1'b0, out_undef, out_result};
        in_valid = 1'b0;
        src_a = $urandom;
        @(negedge clk);
        check("R2", {out_valid, out_undef, out_result}, held);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule